// File: doc/BRIEF.md
# Program Counter with Upper-Bits Latch

This block holds the fetch address of a small microcontroller core. The address is 13 bits wide. Its lower eight bits behave as an ordinary data register: the core can read them, and the core can overwrite them with an ALU result. The upper five bits have no direct read or write path. They are only ever loaded from a separate 5-bit holding latch, which software writes through its own port.

Each cycle the block chooses one source for the next address. It can take a full return address from the stack, a jump target built from an 11-bit literal, an ALU write to the low byte, or a plain increment. If none of these is strobed, it holds its value. The latch supplies the upper bits in two different ways. A low-byte write takes all five latch bits. A jump takes only the top two latch bits, because the literal already covers bits 10:0. A value written to the low byte is eight bits wide, so a computed branch never carries into the upper bits. Software must set the latch before it crosses a 256-word page.

Top module: `pc_unit`

## Requirements
- R1: An active-low asynchronous reset clears all 13 address bits and the 5-bit latch to zero. No clock edge is needed for this.
- R2: A low-byte write loads address bits 7:0 from the write data. In the same cycle it loads bits 12:8 from latch bits 4:0.
- R3: A jump loads address bits 10:0 from the 11-bit literal and bits 12:11 from latch bits 4:3.
- R4: The latch changes only through its own write port, and its read port always shows its value. Jumps, returns, increments and low-byte writes leave it unchanged.
- R5: A return load copies the full 13-bit stack value into the address.
- R6: An increment adds one to the address, and 0x1FFF wraps to 0x0000.
- R7: With no strobe asserted, the address holds its value.
- R8: When several strobes are asserted together, return wins over jump. Jump wins over low-byte write, and low-byte write wins over increment.
- R9: The low-byte read port always equals address bits 7:0.
- R10: A low-byte write never carries into the upper bits. At address 0x0FF with the latch at zero, writing 0x00 gives address 0x000.
- R11: If the latch and the low byte are written in the same cycle, the address takes the latch value from before that write. The new latch value appears on the latch read port after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| adv_i | input | 1 | Advance to the next sequential address |
| lo_wr_i | input | 1 | ALU result targets the low byte |
| lo_wdata_i | input | 8 | ALU result for the low byte |
| jmp_i | input | 1 | Jump or call with literal target |
| jmp_lit_i | input | 11 | Literal target from the opcode |
| ret_i | input | 1 | Load the address from the return stack |
| ret_addr_i | input | 13 | Return address popped from the stack |
| lat_wr_i | input | 1 | Write the upper-bits latch |
| lat_wdata_i | input | 5 | New latch value |
| fetch_addr_o | output | 13 | Current fetch address |
| lo_rdata_o | output | 8 | Readable low byte of the address |
| lat_rdata_o | output | 5 | Latch read value |

## Verification
The clocked assertions assume that reset is released between clock edges. This way the first sampled cycle after reset has defined strobes, and the `$past` terms never see the values that were present during reset. They also assume that every strobe and data input is settled before the rising edge. The bench drives all inputs on the falling edge and releases reset there. It also holds all strobes low around reset, so no load is pending when the first checked edge arrives.

// File: rtl/pc_pkg.sv
package pc_pkg;
  // Source chosen for the next fetch address, in no particular order
  typedef enum logic [2:0] {
    SRC_HOLD = 3'd0,
    SRC_INC  = 3'd1,
    SRC_LOWR = 3'd2,
    SRC_JMP  = 3'd3,
    SRC_RET  = 3'd4
  } pc_src_e;
endpackage

// File: rtl/pc_src_arb.sv
module pc_src_arb
  import pc_pkg::*;
(
  input  logic    ret_i,
  input  logic    jmp_i,
  input  logic    lo_wr_i,
  input  logic    adv_i,
  output pc_src_e src_o
);
  // Fixed priority: return, jump, low-byte write, increment
  always_comb begin
    if (ret_i)        src_o = SRC_RET;
    else if (jmp_i)   src_o = SRC_JMP;
    else if (lo_wr_i) src_o = SRC_LOWR;
    else if (adv_i)   src_o = SRC_INC;
    else              src_o = SRC_HOLD;
  end
endmodule

// File: rtl/pc_next_calc.sv
module pc_next_calc
  import pc_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int LO_W  = 8,
  parameter int LIT_W = 11
) (
  input  pc_src_e               src_i,
  input  logic [PC_W-1:0]       pc_q_i,
  input  logic [PC_W-LO_W-1:0]  lat_i,
  input  logic [LO_W-1:0]       lo_wdata_i,
  input  logic [LIT_W-1:0]      jmp_lit_i,
  input  logic [PC_W-1:0]       ret_addr_i,
  output logic [PC_W-1:0]       pc_d_o
);
  localparam int LAT_W = PC_W - LO_W;
  localparam int JHI_W = PC_W - LIT_W;

  logic [PC_W-1:0] jmp_tgt;
  logic [PC_W-1:0] inc_val;

  // Jump target: literal in the low bits, top latch bits above it
  generate
    if (JHI_W > 0) begin : g_jmp_page
      assign jmp_tgt = {lat_i[LAT_W-1 -: JHI_W], jmp_lit_i};
    end else begin : g_jmp_full
      assign jmp_tgt = jmp_lit_i[PC_W-1:0];
    end
  endgenerate

  // Plain binary wrap at the top of the address space
  assign inc_val = pc_q_i + {{(PC_W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (src_i)
      SRC_RET:  pc_d_o = ret_addr_i;
      SRC_JMP:  pc_d_o = jmp_tgt;
      SRC_LOWR: pc_d_o = {lat_i, lo_wdata_i};
      SRC_INC:  pc_d_o = inc_val;
      default:  pc_d_o = pc_q_i;
    endcase
  end
endmodule

// File: rtl/pc_hilatch.sv
module pc_hilatch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (wr_i) q_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (wr_i) q_o <= q_d;
  end

  AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(q_o)); // R4
  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> q_o == $past(wdata_i)); // R4
endmodule

// File: rtl/pc_unit.sv
module pc_unit
  import pc_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int LO_W  = 8,
  parameter int LIT_W = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv_i,
  input  logic                  lo_wr_i,
  input  logic [LO_W-1:0]       lo_wdata_i,
  input  logic                  jmp_i,
  input  logic [LIT_W-1:0]      jmp_lit_i,
  input  logic                  ret_i,
  input  logic [PC_W-1:0]       ret_addr_i,
  input  logic                  lat_wr_i,
  input  logic [PC_W-LO_W-1:0]  lat_wdata_i,
  output logic [PC_W-1:0]       fetch_addr_o,
  output logic [LO_W-1:0]       lo_rdata_o,
  output logic [PC_W-LO_W-1:0]  lat_rdata_o
);
  localparam int LAT_W = PC_W - LO_W;
  localparam int JHI_W = PC_W - LIT_W;

  pc_src_e           src;
  logic [PC_W-1:0]   pc_d;
  logic [PC_W-1:0]   pc_q;
  logic [LAT_W-1:0]  lat_q;
  logic              pc_en;

  pc_hilatch #(.W(LAT_W)) u_lat (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (lat_wr_i),
    .wdata_i (lat_wdata_i),
    .q_o     (lat_q)
  );

  pc_src_arb u_arb (
    .ret_i   (ret_i),
    .jmp_i   (jmp_i),
    .lo_wr_i (lo_wr_i),
    .adv_i   (adv_i),
    .src_o   (src)
  );

  pc_next_calc #(.PC_W(PC_W), .LO_W(LO_W), .LIT_W(LIT_W)) u_next (
    .src_i      (src),
    .pc_q_i     (pc_q),
    .lat_i      (lat_q),
    .lo_wdata_i (lo_wdata_i),
    .jmp_lit_i  (jmp_lit_i),
    .ret_addr_i (ret_addr_i),
    .pc_d_o     (pc_d)
  );

  assign pc_en = (src != SRC_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign fetch_addr_o = pc_q;
  assign lo_rdata_o   = pc_q[LO_W-1:0];
  assign lat_rdata_o  = lat_q;

  AST_RET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i |=> pc_q == $past(ret_addr_i)); // R5
  AST_JMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_i && jmp_i) |=>
      pc_q == {$past(lat_q[LAT_W-1 -: JHI_W]), $past(jmp_lit_i)}); // R3
  AST_LOWR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_i && !jmp_i && lo_wr_i) |=>
      pc_q == {$past(lat_q), $past(lo_wdata_i)}); // R2
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_i && !jmp_i && !lo_wr_i && adv_i) |=>
      pc_q == $past(pc_q) + {{(PC_W-1){1'b0}}, 1'b1}); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_i && !jmp_i && !lo_wr_i && !adv_i) |=> $stable(pc_q)); // R7
  AST_LO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rdata_o == fetch_addr_o[LO_W-1:0]); // R9
endmodule

// File: tb/sim_pc_unit.sv
module sim_pc_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        adv, lo_wr, jmp, ret, lat_wr;
  logic [7:0]  lo_wdata;
  logic [10:0] jmp_lit;
  logic [12:0] ret_addr;
  logic [4:0]  lat_wdata;
  logic [12:0] fetch_addr;
  logic [7:0]  lo_rdata;
  logic [4:0]  lat_rdata;

  int n_run  = 0;
  int n_fail = 0;
  logic [12:0] m_pc;
  logic [4:0]  m_lat;

  always #5 clk = ~clk;

  pc_unit u0 (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .lo_wr_i(lo_wr), .lo_wdata_i(lo_wdata),
    .jmp_i(jmp), .jmp_lit_i(jmp_lit), .ret_i(ret), .ret_addr_i(ret_addr),
    .lat_wr_i(lat_wr), .lat_wdata_i(lat_wdata), .fetch_addr_o(fetch_addr),
    .lo_rdata_o(lo_rdata), .lat_rdata_o(lat_rdata)
  );

  task automatic chk(input string tag);
    n_run++;
    if (fetch_addr !== m_pc || lo_rdata !== m_pc[7:0] || lat_rdata !== m_lat) begin
      n_fail++;
      $display("FAIL %s: addr=%h lo=%h lat=%h expected addr=%h lo=%h lat=%h",
               tag, fetch_addr, lo_rdata, lat_rdata, m_pc, m_pc[7:0], m_lat);
    end
  endtask

  // Drive at falling edge, apply the model, check at the next falling edge
  task automatic cyc(input logic r, input logic j, input logic l, input logic a,
                     input logic lw, input logic [12:0] ra, input logic [10:0] jl,
                     input logic [7:0] ld, input logic [4:0] lwd, input string tag);
    ret = r; jmp = j; lo_wr = l; adv = a; lat_wr = lw;
    ret_addr = ra; jmp_lit = jl; lo_wdata = ld; lat_wdata = lwd;
    if (r)      m_pc = ra;
    else if (j) m_pc = {m_lat[4:3], jl};
    else if (l) m_pc = {m_lat, ld};
    else if (a) m_pc = m_pc + 13'd1;
    if (lw) m_lat = lwd;
    @(negedge clk);
    chk(tag);
  endtask

  task automatic idle();
    ret = 0; jmp = 0; lo_wr = 0; adv = 0; lat_wr = 0;
  endtask

  task automatic set_lat(input logic [4:0] v);
    cyc(0, 0, 0, 0, 1, 13'd0, 11'd0, 8'd0, v, "R4");
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    ret_addr = 0; jmp_lit = 0; lo_wdata = 0; lat_wdata = 0;
    rst_n = 1'b1;
    #3 rst_n = 1'b0;
    m_pc = 0; m_lat = 0;
    repeat (2) @(negedge clk);
    chk("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1");

    // R2: low-byte write sweep over all latch values and all data bytes
    for (int lv = 0; lv < 32; lv++) begin
      set_lat(lv[4:0]);
      for (int d = 0; d < 256; d++)
        cyc(0, 0, 1, 0, 0, 13'd0, 11'd0, d[7:0], 5'd0, "R2");
    end

    // R3: jump sweep, only top latch bits reach the address
    for (int lv = 0; lv < 32; lv++) begin
      set_lat(lv[4:0]);
      for (int k = 0; k < 2048; k += 97)
        cyc(0, 1, 0, 0, 0, 13'd0, k[10:0], 8'd0, 5'd0, "R3");
      cyc(0, 1, 0, 0, 0, 13'd0, 11'h7FF, 8'd0, 5'd0, "R3");
    end

    // R5: return loads, latch untouched (R4)
    set_lat(5'h0A);
    for (int k = 0; k < 8192; k += 61)
      cyc(1, 0, 0, 0, 0, k[12:0], 11'd0, 8'd0, 5'd0, "R5");
    cyc(1, 0, 0, 0, 0, 13'h1FFF, 11'd0, 8'd0, 5'd0, "R5");

    // R6: increments and the top wrap
    cyc(1, 0, 0, 0, 0, 13'h1FFC, 11'd0, 8'd0, 5'd0, "R5");
    for (int k = 0; k < 6; k++)
      cyc(0, 0, 0, 1, 0, 13'd0, 11'd0, 8'd0, 5'd0, "R6");
    cyc(1, 0, 0, 0, 0, 13'h00FE, 11'd0, 8'd0, 5'd0, "R5");
    for (int k = 0; k < 300; k++)
      cyc(0, 0, 0, 1, 0, 13'd0, 11'd0, 8'd0, 5'd0, "R6");

    // R7: idle holds
    for (int k = 0; k < 5; k++)
      cyc(0, 0, 0, 0, 0, 13'h1234, 11'h3AB, 8'h5C, 5'd0, "R7");

    // R8: all strobe combinations, with distinct data
    set_lat(5'h15);
    for (int m = 0; m < 16; m++) begin
      cyc(1, 0, 0, 0, 0, 13'h0777, 11'd0, 8'd0, 5'd0, "R5");
      cyc(m[3], m[2], m[1], m[0], 0, 13'h1ABC, 11'h4D2, 8'h3E, 5'd0, "R8");
    end

    // R10: no carry from the low byte into the page bits
    set_lat(5'h00);
    cyc(1, 0, 0, 0, 0, 13'h00FF, 11'd0, 8'd0, 5'd0, "R5");
    cyc(0, 0, 1, 0, 0, 13'd0, 11'd0, 8'h00, 5'd0, "R10");
    if (fetch_addr !== 13'h0000) begin
      n_fail++;
      $display("FAIL R10: addr=%h expected 0000", fetch_addr);
    end
    n_run++;

    // R11: latch and low byte written together: old latch used
    set_lat(5'h03);
    cyc(0, 0, 1, 0, 1, 13'd0, 11'd0, 8'h44, 5'h1C, "R11");
    cyc(0, 0, 1, 0, 0, 13'd0, 11'd0, 8'h45, 5'd0, "R11");
    // R4: latch untouched by jump with simultaneous other strobes
    cyc(0, 1, 1, 1, 0, 13'd0, 11'h123, 8'h99, 5'd0, "R4");

    // R1: asynchronous reset mid-cycle
    #2 rst_n = 1'b0;
    #1;
    m_pc = 0; m_lat = 0;
    chk("R1");
    @(negedge clk);
    idle();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule